// File: doc/BRIEF.md
# I2C Read-Only Slave Byte Transmitter

This block is the data-return half of an I2C target. It watches the bus lines through synchronisers. It recognises START and STOP in any state. It compares the first byte after a START with its own 7-bit address. When that byte carries its own address with the read flag set, the block acknowledges it. From then on it shifts bytes supplied by local logic onto SDA. The block never drives a line high. Its two outputs are pull-low enables, intended for open-drain pads with external pull-ups.

Local logic delivers each byte over a valid/ready handshake. While the block waits for a byte (`tx_ready` high), it stretches the clock by holding SCL low. It waits as long as needed. After every byte it samples the master's acknowledge. An ACK starts a request for the next byte. A NACK returns the block to idle with both lines released. A START or STOP at any point abandons the transfer.

The system clock must run at least eight times faster than SCL. The block needs this to see every edge after its two-flop synchroniser.

Top module: `i2c_read_slave`

## Requirements
- R1: After reset, `sda_pull`, `scl_pull` and `tx_ready` are all low.
- R2: `sda_pull` changes only while the synchronised SCL is low.
- R3: An address byte equal to {OWN_ADDR, 1}, sent MSB first, is acknowledged. SDA is pulled low from the falling edge after its eighth bit and released after the falling edge of the ninth clock.
- R4: An address byte with a different address, or with bit 0 (read flag) equal to 0, leaves SDA released. The master then samples 1 on every following clock, including the ninth.
- R5: A data byte is placed on SDA MSB first. Each bit is set up after a falling SCL edge. SDA is released after the eighth falling edge so that the master can acknowledge.
- R6: A master NACK (SDA high at the ninth rising edge) returns the block to idle. No further byte is requested, and SDA stays released on any further clocks.
- R7: After the address ACK, and after each master ACK, `tx_ready` rises and SCL is held low until `tx_valid` is seen. SCL is released the cycle after the byte is taken, and SDA is released throughout the hold.
- R8: A START or STOP in the middle of a byte abandons the transfer. Both enables fall and `tx_ready` is low. A new START begins address reception again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull | output | 1 | Pull SCL low when high (clock stretch) |
| sda_pull | output | 1 | Pull SDA low when high |
| tx_data | input | 8 | Next byte to return to the master |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_ready | output | 1 | Block takes `tx_data` when both are high |

## Verification
Two events can land in the same system cycle: taking a byte from the handshake and ending the clock stretch. A byte that is already valid when the ninth falling edge arrives is taken the cycle after the hold begins. A byte that arrives late releases SCL at whatever cycle `tx_valid` appears. The bench provokes both cases, first with bytes queued ahead of a multi-byte read and then with bytes withheld for a hundred cycles. In each case it judges the bytes the master clocks out and the level of SCL during the hold.

// File: rtl/i2c_read_slave.sv
module i2c_read_slave #(
  parameter logic [6:0] OWN_ADDR = 7'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready
);
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W) + 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_LOAD, S_TX, S_MACK} st_t;

  st_t              st;
  logic [1:0]       scl_sync, sda_sync;
  logic             scl_q, sda_q, mack;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0] cnt;

  wire scl_s     = scl_sync[1];
  wire sda_s     = sda_sync[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sh       <= '0;
      cnt      <= '0;
      mack     <= 1'b1;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      st       <= S_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      st       <= S_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        S_ADDR:
          if (scl_rise) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
            if (sh == {OWN_ADDR, 1'b1}) begin
              st       <= S_AACK;
              sda_pull <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
        S_AACK:
          if (scl_fall) begin
            st       <= S_LOAD;
            sda_pull <= 1'b0;
          end
        S_LOAD:
          if (tx_valid) begin
            sh       <= tx_data;
            sda_pull <= ~tx_data[BYTE_W-1];
            cnt      <= '0;
            st       <= S_TX;
          end
        S_TX:
          if (scl_fall) begin
            if (cnt == CNT_W'(BYTE_W - 1)) begin
              st       <= S_MACK;
              sda_pull <= 1'b0;
            end else begin
              sh       <= {sh[BYTE_W-2:0], 1'b0};
              sda_pull <= ~sh[BYTE_W-2];
              cnt      <= cnt + 1'b1;
            end
          end
        S_MACK:
          if (scl_rise) mack <= sda_s;
          else if (scl_fall) st <= mack ? S_IDLE : S_LOAD;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scl_pull = (st == S_LOAD);
  assign tx_ready = (st == S_LOAD);

  assert_sda_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_s);

  assert_stretch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull && !tx_valid) |=> scl_pull);

  assert_stretch_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull) |-> $past(tx_valid));

  assert_stretch_sda_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> !sda_pull);

  assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_pull && !scl_pull));
endmodule

// File: tb/i2c_read_slave_tb.sv
module i2c_read_slave_tb;
  localparam logic [6:0] OWN = 7'h5A;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_pull, sda_pull, tx_ready, tx_valid;
  logic [7:0] tx_data;
  logic [7:0] src [0:31];
  int n_src = 0, idx = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wire scl_line = ~(m_scl_low | scl_pull);
  wire sda_line = ~(m_sda_low | sda_pull);

  assign tx_valid = (idx < n_src);
  assign tx_data  = src[idx[4:0]];

  always @(posedge clk) if (tx_valid && tx_ready) idx <= idx + 1;

  i2c_read_slave #(.OWN_ADDR(OWN)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready));

  // {expect address ACK, address byte, data byte}
  localparam logic [16:0] VEC [0:5] = '{
    {1'b1, OWN, 1'b1, 8'hA5},
    {1'b1, OWN, 1'b1, 8'h3C},
    {1'b0, 7'h21, 1'b1, 8'h77},
    {1'b0, OWN, 1'b0, 8'h12},
    {1'b1, OWN, 1'b1, 8'hFF},
    {1'b1, OWN, 1'b1, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic supply(input logic [7:0] b);
    src[n_src[4:0]] = b;
    n_src++;
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; tick(Q);
    m_scl_low = 1'b0;
    while (!scl_line) tick(1);
    tick(Q);
    m_sda_low = 1'b1; tick(Q);
    m_scl_low = 1'b1; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda_low = 1'b1; tick(Q);
    m_scl_low = 1'b0;
    while (!scl_line) tick(1);
    tick(Q);
    m_sda_low = 1'b0; tick(Q);
  endtask

  task automatic clk_bit(input bit drive_low, output bit sampled);
    m_sda_low = drive_low; tick(Q);
    m_scl_low = 1'b0;
    while (!scl_line) tick(1);
    tick(Q);
    sampled = sda_line;
    tick(Q);
    m_scl_low = 1'b1; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit acked);
    bit s;
    for (int i = 7; i >= 0; i--) clk_bit(~b[i], s);
    clk_bit(1'b0, s);
    acked = ~s;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b0, s);
      b[i] = s;
    end
    clk_bit(give_ack, s);
    m_sda_low = 1'b0;
  endtask

  initial begin
    bit ack;
    logic [7:0] rd;
    tick(5);
    chk(sda_pull == 0 && scl_pull == 0 && tx_ready == 0, "R1 reset", {sda_pull, scl_pull, tx_ready}, 0);
    rst_n = 1'b1;
    tick(10);
    chk(sda_pull == 0 && scl_pull == 0 && tx_ready == 0, "R1 after reset", {sda_pull, scl_pull, tx_ready}, 0);

    for (int v = 0; v < 6; v++) begin
      if (VEC[v][16]) supply(VEC[v][7:0]);
      bus_start();
      write_byte(VEC[v][15:8], ack);
      chk(ack == VEC[v][16], VEC[v][16] ? "R3 address ack" : "R4 address ignored", ack, VEC[v][16]);
      read_byte(1'b0, rd);
      chk(rd == (VEC[v][16] ? VEC[v][7:0] : 8'hFF), "R5 read data", rd, VEC[v][16] ? VEC[v][7:0] : 8'hFF);
      bus_stop();
      tick(Q);
    end

    // R5/R6: multi-byte with bytes queued ahead, then NACK ends transfer
    supply(8'h11); supply(8'h22); supply(8'h33);
    bus_start();
    write_byte({OWN, 1'b1}, ack);
    read_byte(1'b1, rd); chk(rd == 8'h11, "R5 burst byte0", rd, 8'h11);
    read_byte(1'b1, rd); chk(rd == 8'h22, "R5 burst byte1", rd, 8'h22);
    read_byte(1'b0, rd); chk(rd == 8'h33, "R6 last byte", rd, 8'h33);
    tick(5);
    chk(sda_pull == 0 && scl_pull == 0 && tx_ready == 0, "R6 idle after NACK", {sda_pull, scl_pull, tx_ready}, 0);
    read_byte(1'b0, rd);
    chk(rd == 8'hFF, "R6 no data after NACK", rd, 8'hFF);
    chk(tx_ready == 0 && idx == n_src, "R6 no byte requested", idx, n_src);
    bus_stop();

    // R7: stretch after address ACK and after master ACK
    bus_start();
    write_byte({OWN, 1'b1}, ack);
    chk(ack == 1, "R3 ack before stretch", ack, 1);
    tick(100);
    chk(scl_line == 0 && tx_ready == 1 && sda_pull == 0, "R7 SCL held, SDA free", {scl_line, tx_ready, sda_pull}, 3'b010);
    supply(8'hC3);
    tick(3);
    chk(scl_pull == 0, "R7 SCL released after byte", scl_pull, 0);
    read_byte(1'b1, rd);
    chk(rd == 8'hC3, "R7 stretched byte", rd, 8'hC3);
    tick(100);
    chk(scl_line == 0 && tx_ready == 1, "R7 hold between bytes", {scl_line, tx_ready}, 2'b01);
    supply(8'h81);
    read_byte(1'b0, rd);
    chk(rd == 8'h81, "R7 second stretched byte", rd, 8'h81);
    bus_stop();

    // R8: repeated START in the middle of a byte
    supply(8'hF0);
    bus_start();
    write_byte({OWN, 1'b1}, ack);
    begin bit s; clk_bit(1'b0, s); clk_bit(1'b0, s); end
    bus_start();
    tick(3);
    chk(sda_pull == 0 && scl_pull == 0 && tx_ready == 0, "R8 START aborts", {sda_pull, scl_pull, tx_ready}, 0);
    supply(8'h6E);
    write_byte({OWN, 1'b1}, ack);
    chk(ack == 1, "R8 readdress after START", ack, 1);
    read_byte(1'b0, rd);
    chk(rd == 8'h6E, "R8 fresh byte after START", rd, 8'h6E);
    bus_stop();

    // R8: STOP in the middle of a byte
    supply(8'hE7);
    bus_start();
    write_byte({OWN, 1'b1}, ack);
    begin bit s; clk_bit(1'b0, s); end
    bus_stop();
    tick(3);
    chk(sda_pull == 0 && scl_pull == 0 && tx_ready == 0, "R8 STOP aborts", {sda_pull, scl_pull, tx_ready}, 0);
    tick(Q);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule